// File: doc/BRIEF.md
# Interleaved Multithread Issue Scheduler

This block is the issue stage of a barrel processor. It holds a fixed set of hardware thread contexts, one per pipeline stage, and each cycle hands one eligible thread to the pipeline. Each context keeps a program counter. The issued thread number doubles as the register-bank select for the downstream register file. Successive slots go to different threads, so the pipeline behind it needs no interlocks and no forwarding.

A thread that has issued waits until its result leaves the pipeline, which the completion strobe reports. A completion can also redirect the thread to a new PC or retire it to idle. If the instruction in flight misses in the cache, the thread is parked and its PC is rewound to the missed instruction. It stays out of the rotation until a single shared line-fill unit has served it, and the other threads keep issuing meanwhile. Misses that arrive while a fill is running queue up and are granted the fill unit in round-robin order. An idle context can be started in one clock by loading a start PC.

Top module: `barrel_issue_sched`

## Requirements
- R1: After reset, context 0 is ready at RESET_PC and all other contexts are idle. The outputs then show issue_valid=1, issue_tid=0, issue_pc=RESET_PC and fill_start=0.
- R2: Each cycle the issued thread is the first ready context found searching upward (with wrap-around) from the one after the last issued thread. When no context is ready, issue_valid is 0.
- R3: An issued thread is not eligible again until its completion strobe arrives, so one thread never takes two consecutive slots. Its PC advances by PC_STEP at issue.
- R4: A completion for a thread waiting on its result makes the thread ready. With cmp_redir=1 its PC becomes cmp_target. With cmp_halt=1 the thread goes idle instead.
- R5: A miss for a thread waiting on its result parks that thread and rewinds its PC by PC_STEP. The thread is skipped until its fill completes, and other threads issue during the fill.
- R6: One fill runs at a time. fill_start pulses with fill_tid in the cycle after a miss is accepted when the fill unit is free. A miss during a fill waits until fill_done frees the unit, and waiting misses are granted round-robin. fill_done makes the filling thread ready.
- R7: A fork to an idle context loads fork_pc, and that context is ready in the next cycle.
- R8: The following strobes are ignored: a completion or miss for a thread that is not waiting on a result, a fork to a context that is not idle, and fill_done while no fill is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fork_valid | input | 1 | Start-thread strobe |
| fork_tid | input | TID_W | Context to start |
| fork_pc | input | PC_W | Start PC |
| cmp_valid | input | 1 | Result-completion strobe |
| cmp_tid | input | TID_W | Thread whose result completed |
| cmp_halt | input | 1 | Completing thread goes idle |
| cmp_redir | input | 1 | Completing thread takes cmp_target |
| cmp_target | input | PC_W | Redirect PC |
| miss_valid | input | 1 | Cache-miss strobe |
| miss_tid | input | TID_W | Thread that missed |
| fill_done | input | 1 | Line fill in progress has finished |
| issue_valid | output | 1 | A thread issues this cycle |
| issue_tid | output | TID_W | Issued thread, also the register-bank select |
| issue_pc | output | PC_W | PC of the issued instruction |
| fill_start | output | 1 | Fill unit is granted this cycle |
| fill_tid | output | TID_W | Thread the fill serves |

## Verification
The issue outputs and the fill grant are combinational from registered context state. Any strobe applied in a cycle therefore shows its effect on the outputs right after the next rising edge. A fill_start caused by a miss appears one cycle after the miss is accepted, because the pending bit must be registered first. The bench drives each stimulus at a falling edge and samples the outputs at the following falling edge, which is exactly one register stage later. Ignored strobes are checked the same way: the output they could have altered is observed in the next cycle.

// File: rtl/barrel_sched_pkg.sv
package barrel_sched_pkg;

    typedef enum logic [1:0] {
        CTX_IDLE  = 2'd0,
        CTX_READY = 2'd1,
        CTX_WRES  = 2'd2,
        CTX_WMISS = 2'd3
    } ctx_state_e;

    function automatic logic is_ready(input ctx_state_e s);
        return s == CTX_READY;
    endfunction

    function automatic logic is_waiting_result(input ctx_state_e s);
        return s == CTX_WRES;
    endfunction

endpackage

// File: rtl/rr_picker.sv
module rr_picker #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic          adv,
    output logic          gnt_valid,
    output logic [IW-1:0] gnt_idx
);
    logic [IW-1:0] last_q;
    logic [IW-1:0] idx_c;

    always_comb begin
        int j;
        idx_c = '0;
        for (int k = N; k >= 1; k--) begin
            j = int'(last_q) + k;
            if (j >= N) j = j - N;
            if (req[j]) idx_c = IW'(j);
        end
    end

    assign gnt_valid = |req;
    assign gnt_idx   = idx_c;

    always_ff @(posedge clk) begin
        if (rst)                  last_q <= IW'(N - 1);
        else if (adv && gnt_valid) last_q <= idx_c;
    end

    // R2
    rr_grant_chk: assert property (@(posedge clk) disable iff (rst)
        gnt_valid |-> req[gnt_idx]);

endmodule

// File: rtl/thread_ctx.sv
module thread_ctx
    import barrel_sched_pkg::*;
#(
    parameter int              PC_W     = 32,
    parameter bit              BOOT     = 1'b0,
    parameter logic [PC_W-1:0] RESET_PC = '0,
    parameter logic [PC_W-1:0] PC_STEP  = PC_W'(4)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            issue_sel,
    input  logic            cmp_sel,
    input  logic            cmp_halt,
    input  logic            cmp_redir,
    input  logic [PC_W-1:0] cmp_target,
    input  logic            miss_sel,
    input  logic            fill_done_sel,
    input  logic            fork_sel,
    input  logic [PC_W-1:0] fork_pc,
    output ctx_state_e      state_o,
    output logic [PC_W-1:0] pc_o
);
    ctx_state_e      state_q;
    logic [PC_W-1:0] pc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BOOT ? CTX_READY : CTX_IDLE;
            pc_q    <= BOOT ? RESET_PC : '0;
        end else begin
            unique case (state_q)
                CTX_IDLE: if (fork_sel) begin
                    state_q <= CTX_READY;
                    pc_q    <= fork_pc;
                end
                CTX_READY: if (issue_sel) begin
                    state_q <= CTX_WRES;
                    pc_q    <= pc_q + PC_STEP;
                end
                CTX_WRES: begin
                    if (miss_sel) begin
                        state_q <= CTX_WMISS;
                        pc_q    <= pc_q - PC_STEP;
                    end else if (cmp_sel) begin
                        state_q <= cmp_halt ? CTX_IDLE : CTX_READY;
                        if (cmp_redir) pc_q <= cmp_target;
                    end
                end
                CTX_WMISS: if (fill_done_sel) state_q <= CTX_READY;
                default: state_q <= CTX_IDLE;
            endcase
        end
    end

    assign state_o = state_q;
    assign pc_o    = pc_q;

    // R3
    wres_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == CTX_WRES && !cmp_sel && !miss_sel) |=> state_q == CTX_WRES);

    // R5
    miss_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == CTX_WMISS && !fill_done_sel) |=> state_q == CTX_WMISS);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == CTX_IDLE && !fork_sel) |=> state_q == CTX_IDLE);

endmodule

// File: rtl/fill_tracker.sv
module fill_tracker #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          miss_acc,
    input  logic [IW-1:0] miss_tid,
    input  logic          fill_done,
    output logic [N-1:0]  done_vec,
    output logic          fill_start,
    output logic [IW-1:0] fill_tid
);
    logic [N-1:0]  pending_q;
    logic          busy_q;
    logic [IW-1:0] owner_q;
    logic          any_wait;
    logic [IW-1:0] pick;
    logic          grant;

    rr_picker #(.N(N)) u_fill_rr (
        .clk       (clk),
        .rst       (rst),
        .req       (pending_q),
        .adv       (grant),
        .gnt_valid (any_wait),
        .gnt_idx   (pick)
    );

    assign grant      = !busy_q && any_wait;
    assign fill_start = grant;
    assign fill_tid   = pick;
    assign done_vec   = (busy_q && fill_done) ? (N'(1) << owner_q) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= '0;
            busy_q    <= 1'b0;
            owner_q   <= '0;
        end else begin
            if (grant) begin
                busy_q          <= 1'b1;
                owner_q         <= pick;
                pending_q[pick] <= 1'b0;
            end else if (busy_q && fill_done) begin
                busy_q <= 1'b0;
            end
            if (miss_acc) pending_q[miss_tid] <= 1'b1;
        end
    end

    // R6
    fill_single_chk: assert property (@(posedge clk) disable iff (rst)
        fill_start |=> !fill_start);

endmodule

// File: rtl/barrel_issue_sched.sv
module barrel_issue_sched
    import barrel_sched_pkg::*;
#(
    parameter int              NUM_THREADS = 4,
    parameter int              PC_W        = 32,
    parameter logic [PC_W-1:0] RESET_PC    = PC_W'(32'h0000_1000),
    parameter logic [PC_W-1:0] PC_STEP     = PC_W'(4),
    localparam int             TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fork_valid,
    input  logic [TID_W-1:0] fork_tid,
    input  logic [PC_W-1:0]  fork_pc,
    input  logic             cmp_valid,
    input  logic [TID_W-1:0] cmp_tid,
    input  logic             cmp_halt,
    input  logic             cmp_redir,
    input  logic [PC_W-1:0]  cmp_target,
    input  logic             miss_valid,
    input  logic [TID_W-1:0] miss_tid,
    input  logic             fill_done,
    output logic             issue_valid,
    output logic [TID_W-1:0] issue_tid,
    output logic [PC_W-1:0]  issue_pc,
    output logic             fill_start,
    output logic [TID_W-1:0] fill_tid
);
    ctx_state_e             ctx_st [NUM_THREADS];
    logic [PC_W-1:0]        ctx_pc [NUM_THREADS];
    logic [NUM_THREADS-1:0] ready_vec;
    logic [NUM_THREADS-1:0] done_vec;
    logic                   miss_acc;

    for (genvar i = 0; i < NUM_THREADS; i++) begin : g_ctx
        thread_ctx #(
            .PC_W     (PC_W),
            .BOOT     (i == 0),
            .RESET_PC (RESET_PC),
            .PC_STEP  (PC_STEP)
        ) u_ctx (
            .clk           (clk),
            .rst           (rst),
            .issue_sel     (issue_valid && issue_tid == TID_W'(i)),
            .cmp_sel       (cmp_valid && cmp_tid == TID_W'(i)),
            .cmp_halt      (cmp_halt),
            .cmp_redir     (cmp_redir),
            .cmp_target    (cmp_target),
            .miss_sel      (miss_valid && miss_tid == TID_W'(i)),
            .fill_done_sel (done_vec[i]),
            .fork_sel      (fork_valid && fork_tid == TID_W'(i)),
            .fork_pc       (fork_pc),
            .state_o       (ctx_st[i]),
            .pc_o          (ctx_pc[i])
        );
        assign ready_vec[i] = is_ready(ctx_st[i]);
    end

    rr_picker #(.N(NUM_THREADS)) u_issue_rr (
        .clk       (clk),
        .rst       (rst),
        .req       (ready_vec),
        .adv       (1'b1),
        .gnt_valid (issue_valid),
        .gnt_idx   (issue_tid)
    );

    assign issue_pc = ctx_pc[issue_tid];
    assign miss_acc = miss_valid && is_waiting_result(ctx_st[miss_tid]);

    fill_tracker #(.N(NUM_THREADS)) u_fill (
        .clk        (clk),
        .rst        (rst),
        .miss_acc   (miss_acc),
        .miss_tid   (miss_tid),
        .fill_done  (fill_done),
        .done_vec   (done_vec),
        .fill_start (fill_start),
        .fill_tid   (fill_tid)
    );

    // R3
    no_back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
        issue_valid |=> !(issue_valid && issue_tid == $past(issue_tid)));

endmodule

// File: tb/tb_barrel_issue_sched.sv
`timescale 1ns/1ps
module tb_barrel_issue_sched;

    localparam int NT   = 4;
    localparam int TW   = 2;
    localparam int PW   = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          fork_valid;
    logic [TW-1:0] fork_tid;
    logic [PW-1:0] fork_pc;
    logic          cmp_valid;
    logic [TW-1:0] cmp_tid;
    logic          cmp_halt;
    logic          cmp_redir;
    logic [PW-1:0] cmp_target;
    logic          miss_valid;
    logic [TW-1:0] miss_tid;
    logic          fill_done;
    logic          issue_valid;
    logic [TW-1:0] issue_tid;
    logic [PW-1:0] issue_pc;
    logic          fill_start;
    logic [TW-1:0] fill_tid;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    barrel_issue_sched #(.NUM_THREADS(NT), .PC_W(PW)) dut (
        .clk(clk), .rst(rst),
        .fork_valid(fork_valid), .fork_tid(fork_tid), .fork_pc(fork_pc),
        .cmp_valid(cmp_valid), .cmp_tid(cmp_tid), .cmp_halt(cmp_halt),
        .cmp_redir(cmp_redir), .cmp_target(cmp_target),
        .miss_valid(miss_valid), .miss_tid(miss_tid), .fill_done(fill_done),
        .issue_valid(issue_valid), .issue_tid(issue_tid), .issue_pc(issue_pc),
        .fill_start(fill_start), .fill_tid(fill_tid)
    );

    typedef struct packed {
        logic          fv;
        logic [TW-1:0] ftid;
        logic [PW-1:0] fpc;
        logic          cv;
        logic [TW-1:0] ctid;
        logic          chalt;
        logic          credir;
        logic [PW-1:0] ctgt;
        logic          mv;
        logic [TW-1:0] mtid;
        logic          fd;
        logic          ev;
        logic [TW-1:0] etid;
        logic [PW-1:0] epc;
        logic          efs;
        logic [TW-1:0] eftid;
        logic [3:0]    req;
    } step_t;

    localparam int NSTEP = 14;
    localparam step_t STEPS [NSTEP] = '{
        // R7: fork thread 1
        '{1'b1, 2'd1, 32'h2000, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 1'b0, 2'd0, 1'b0, 1'b1, 2'd1, 32'h2000, 1'b0, 2'd0, 4'd7},
        // R7: fork thread 2
        '{1'b1, 2'd2, 32'h3000, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 1'b0, 2'd0, 1'b0, 1'b1, 2'd2, 32'h3000, 1'b0, 2'd0, 4'd7},
        // R2 R4: fork 3 plus completion of 0, rotation picks 3 first
        '{1'b1, 2'd3, 32'h4000, 1'b1, 2'd0, 1'b0, 1'b0, 32'h0, 1'b0, 2'd0, 1'b0, 1'b1, 2'd3, 32'h4000, 1'b0, 2'd0, 4'd2},
        // R3: thread 0 resumes at stepped PC
        '{1'b0, 2'd0, 32'h0,    1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 32'h1004, 1'b0, 2'd0, 4'd3},
        // R6: miss on 1, fill granted next cycle, bubble
        '{1'b0, 2'd0, 32'h0,    1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 1'b1, 2'd1, 1'b0, 1'b0, 2'd0, 32'h0,    1'b1, 2'd1, 4'd6},
        // R6: miss on 2 while fill busy waits
        '{1'b0, 2'd0, 32'h0,    1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 1'b1, 2'd2, 1'b0, 1'b0, 2'd0, 32'h0,    1'b0, 2'd0, 4'd6},
        // R5: others issue during the fill
        '{1'b0, 2'd0, 32'h0,    1'b1, 2'd3, 1'b0, 1'b0, 32'h0, 1'b0, 2'd0, 1'b0, 1'b1, 2'd3, 32'h4004, 1'b0, 2'd0, 4'd5},
        // R5 R6: fill done, 1 back at rewound PC, 2 granted
        '{1'b0, 2'd0, 32'h0,    1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 1'b0, 2'd0, 1'b1, 1'b1, 2'd1, 32'h2000, 1'b1, 2'd2, 4'd5},
        // R2: nobody ready, bubble
        '{1'b0, 2'd0, 32'h0,    1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 32'h0,    1'b0, 2'd0, 4'd2},
        // R6: second fill done
        '{1'b0, 2'd0, 32'h0,    1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 1'b0, 2'd0, 1'b1, 1'b1, 2'd2, 32'h3000, 1'b0, 2'd0, 4'd6},
        // R4: halt thread 0
        '{1'b0, 2'd0, 32'h0,    1'b1, 2'd0, 1'b1, 1'b0, 32'h0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 32'h0,    1'b0, 2'd0, 4'd4},
        // R7: restart thread 0
        '{1'b1, 2'd0, 32'h5000, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 32'h5000, 1'b0, 2'd0, 4'd7},
        // R4: redirect thread 1
        '{1'b0, 2'd0, 32'h0,    1'b1, 2'd1, 1'b0, 1'b1, 32'h6000, 1'b0, 2'd0, 1'b0, 1'b1, 2'd1, 32'h6000, 1'b0, 2'd0, 4'd4},
        // R8: fill_done with no fill running
        '{1'b0, 2'd0, 32'h0,    1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 1'b0, 2'd0, 1'b1, 1'b0, 2'd0, 32'h0,    1'b0, 2'd0, 4'd8}
    };

    task automatic chk(input string req, input string what,
                       input logic [PW-1:0] act, input logic [PW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        fork_valid = 0; fork_tid = '0; fork_pc = '0;
        cmp_valid = 0; cmp_tid = '0; cmp_halt = 0; cmp_redir = 0; cmp_target = '0;
        miss_valid = 0; miss_tid = '0; fill_done = 0;
    endtask

    task automatic do_reset();
        idle_inputs();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic chk_issue(input string req, input logic ev,
                             input logic [TW-1:0] et, input logic [PW-1:0] ep);
        chk(req, "issue_valid", PW'(issue_valid), PW'(ev));
        if (ev) begin
            chk(req, "issue_tid", PW'(issue_tid), PW'(et));
            chk(req, "issue_pc", issue_pc, ep);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
            finish_run();
        end
    end

    initial begin
        string rq;
        do_reset();
        // R1: reset state
        chk_issue("R1", 1'b1, 2'd0, 32'h1000);
        chk("R1", "fill_start", PW'(fill_start), '0);

        for (int s = 0; s < NSTEP; s++) begin
            rq = $sformatf("R%0d step%0d", STEPS[s].req, s);
            fork_valid = STEPS[s].fv;   fork_tid = STEPS[s].ftid; fork_pc = STEPS[s].fpc;
            cmp_valid  = STEPS[s].cv;   cmp_tid  = STEPS[s].ctid;
            cmp_halt   = STEPS[s].chalt; cmp_redir = STEPS[s].credir;
            cmp_target = STEPS[s].ctgt;
            miss_valid = STEPS[s].mv;   miss_tid = STEPS[s].mtid;
            fill_done  = STEPS[s].fd;
            @(negedge clk);
            chk_issue(rq, STEPS[s].ev, STEPS[s].etid, STEPS[s].epc);
            chk(rq, "fill_start", PW'(fill_start), PW'(STEPS[s].efs));
            if (STEPS[s].efs) chk(rq, "fill_tid", PW'(fill_tid), PW'(STEPS[s].eftid));
        end
        idle_inputs();

        // R1: reset again mid-run
        do_reset();
        chk_issue("R1", 1'b1, 2'd0, 32'h1000);

        // R8: completion for idle 2 and miss for idle 3 ignored
        cmp_valid = 1; cmp_tid = 2'd2; miss_valid = 1; miss_tid = 2'd3;
        @(negedge clk);
        idle_inputs();
        chk_issue("R8", 1'b0, 2'd0, 32'h0);
        chk("R8", "fill_start", PW'(fill_start), '0);

        // R8: fork to busy thread 0 ignored
        fork_valid = 1; fork_tid = 2'd0; fork_pc = 32'h7000;
        @(negedge clk);
        idle_inputs();
        chk_issue("R8", 1'b0, 2'd0, 32'h0);
        cmp_valid = 1; cmp_tid = 2'd0;
        @(negedge clk);
        idle_inputs();
        chk_issue("R8", 1'b1, 2'd0, 32'h1004);

        // R2: rotation resumes after last issued
        fork_valid = 1; fork_tid = 2'd3; fork_pc = 32'h8000;
        @(negedge clk);
        idle_inputs();
        chk_issue("R7", 1'b1, 2'd3, 32'h8000);
        fork_valid = 1; fork_tid = 2'd1; fork_pc = 32'hA000; cmp_valid = 1; cmp_tid = 2'd0;
        @(negedge clk);
        idle_inputs();
        chk_issue("R2", 1'b1, 2'd0, 32'h1008);
        @(negedge clk);
        chk_issue("R2", 1'b1, 2'd1, 32'hA000);

        // R8: miss for a ready thread ignored (no fill, PC not rewound)
        miss_valid = 1; miss_tid = 2'd1;
        @(negedge clk);
        idle_inputs();
        chk_issue("R8", 1'b0, 2'd0, 32'h0);
        chk("R8", "fill_start", PW'(fill_start), '0);
        cmp_valid = 1; cmp_tid = 2'd1;
        @(negedge clk);
        idle_inputs();
        chk_issue("R8", 1'b1, 2'd1, 32'hA004);

        finish_run();
    end

endmodule